// File: doc/BRIEF.md
# Eight-Digit Zero-Suppressing Segment Display Driver

This block turns an eight-digit decimal value into eight active-low seven-segment patterns. The value is four integer digits followed by four fraction digits, with the decimal point between them. One strobe captures all eight BCD digits at once. The block then shows the number as it would be written by hand: zeros ahead of the first significant integer digit are dark, and zeros after the last significant fraction digit are dark. For example, the value 0060.0300 appears as `60.03`, and every other position is unlit.

Each digit has a stored code, a decoder and a blank-propagation signal. The integer digits pass the blank signal from the most significant digit down toward the units digit. The fraction digits pass it from the least significant digit up toward the tenths digit. The units digit and the tenths digit never take part in suppression, so an all-zero value reads `0.0`.

A counter runs over a fixed period and forces every digit dark for the off share of that period. The `duty` input sets the lit share, which dims the whole display.

Top module: `zero_blank_display`

## Requirements
- R1: The stored value changes only on a clock edge where `load` is high. All eight digits are captured at that same edge. The new segment patterns appear at the outputs one clock edge later.
- R2: While `load` is low, changes on `digits_in` have no effect on `seg_n`.
- R3: Segment vectors are active low, with bit 0 = segment a through bit 6 = segment g. Digit k uses `seg_n[7k+6:7k]`, and k = 0 is the rightmost fraction digit. The lit patterns (bits g..a, 1 = lit) are: 0:0111111, 1:0000110, 2:1011011, 3:1001111, 4:1100110, 5:1101101, 6:1111101, 7:0000111, 8:1111111, 9:1101111.
- R4: A digit code from 10 to 15 shows all segments off. It does not count as a zero for suppression, so suppression stops at that digit.
- R5: The most significant integer digit is dark when it holds zero. Each lower integer digit except the units digit is dark when it holds zero and every integer digit above it also holds zero.
- R6: The units digit (k = 4) is never suppressed, so a zero there shows the zero pattern whenever the display is lit.
- R7: The least significant fraction digit is dark when it holds zero. Each higher fraction digit except the tenths digit is dark when it holds zero and every fraction digit below it also holds zero.
- R8: The tenths digit (k = 3) is never suppressed.
- R9: Brightness follows a period of 2^PWM_W − 1 cycles. With `duty` = D, every digit is lit in exactly D cycles of any window of that length. D = 0 keeps all digits dark, and D = 2^PWM_W − 1 keeps them lit all the time.
- R10: While reset is held, and for two cycles after it is released, every `seg_n` bit is 1. The stored digits reset to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| load | input | 1 | Captures `digits_in` into every digit at this edge |
| digits_in | input | 4*(NUM_INT+NUM_FRAC) | BCD digits, nibble k is digit k, nibble 0 is the rightmost |
| duty | input | PWM_W | Number of lit cycles per brightness period |
| seg_n | output | 7*(NUM_INT+NUM_FRAC) | Active-low segments, seven bits per digit |

## Verification
The hardest cases to reach are values where suppression must stop in the middle of a chain. This happens when a non-zero digit, or a digit code from 10 to 15, sits between zeros. The outcome then depends on the full path of the ripple in both directions at once. The stimulus applies directed values that place the first significant digit at each integer and fraction position, including 0060.0300, 0000.0000, 1000.0001 and values that contain codes 10 to 15. These are followed by random digit mixes that are weighted toward zeros. Brightness is checked separately by counting lit cycles over one full period at several duty settings.

// File: rtl/zbd_pkg.sv
package zbd_pkg;
  typedef logic [3:0] bcd_t;
  typedef logic [6:0] seg_t;

  localparam seg_t SEG_DARK = 7'h7F;

  // Active-low pattern; bit 0 = a ... bit 6 = g.
  function automatic seg_t glyph_n(input bcd_t v);
    seg_t lit;
    case (v)
      4'd0: lit = 7'h3F;
      4'd1: lit = 7'h06;
      4'd2: lit = 7'h5B;
      4'd3: lit = 7'h4F;
      4'd4: lit = 7'h66;
      4'd5: lit = 7'h6D;
      4'd6: lit = 7'h7D;
      4'd7: lit = 7'h07;
      4'd8: lit = 7'h7F;
      4'd9: lit = 7'h6F;
      default: lit = 7'h00;
    endcase
    return ~lit;
  endfunction
endpackage

// File: rtl/zbd_reset_sync.sv
module zbd_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb sync_d = {sync_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= sync_d;
  end

  assign rst_ok = sync_q[1];
endmodule

// File: rtl/zbd_pwm.sv
module zbd_pwm #(
  parameter int PWM_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PWM_W-1:0] duty,
  output logic             lit
);
  localparam logic [PWM_W-1:0] LAST = {{(PWM_W-1){1'b1}}, 1'b0};

  logic [PWM_W-1:0] cnt_q;
  logic [PWM_W-1:0] cnt_d;

  always_comb begin
    if (cnt_q == LAST) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign lit = (cnt_q < duty);
endmodule

// File: rtl/zbd_digit.sv
module zbd_digit
  import zbd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  bcd_t din,
  input  logic blank_in,
  input  logic lit,
  output logic blank_out,
  output seg_t seg_n
);
  bcd_t code_q, code_d;
  seg_t seg_q, seg_d;
  logic is_zero;
  logic suppress;

  always_comb begin
    code_d = code_q;
    if (load) code_d = din;
  end

  assign is_zero   = (code_q == 4'd0);
  assign suppress  = blank_in & is_zero;
  assign blank_out = suppress;

  always_comb begin
    if (!lit || suppress) seg_d = SEG_DARK;
    else                  seg_d = glyph_n(code_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      seg_q  <= SEG_DARK;
    end else begin
      code_q <= code_d;
      seg_q  <= seg_d;
    end
  end

  assign seg_n = seg_q;
endmodule

// File: rtl/zero_blank_display.sv
module zero_blank_display #(
  parameter int NUM_INT  = 4,
  parameter int NUM_FRAC = 4,
  parameter int PWM_W    = 8
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic                                load,
  input  logic [4*(NUM_INT+NUM_FRAC)-1:0]     digits_in,
  input  logic [PWM_W-1:0]                    duty,
  output logic [7*(NUM_INT+NUM_FRAC)-1:0]     seg_n
);
  localparam int NDIG  = NUM_INT + NUM_FRAC;
  localparam int UNITS = NUM_FRAC;
  localparam int TENTH = NUM_FRAC - 1;

  logic            rst_ok;
  logic            lit;
  logic [NDIG-1:0] rb_in;
  logic [NDIG-1:0] rb_out;

  zbd_reset_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_ok(rst_ok));

  zbd_pwm #(.PWM_W(PWM_W)) u_pwm (
    .clk(clk), .rst_n(rst_ok), .duty(duty), .lit(lit)
  );

  for (genvar k = 0; k < NDIG; k++) begin : g_dig
    if (k == UNITS || k == TENTH) begin : g_keep
      assign rb_in[k] = 1'b0;
    end else if (k == NDIG-1 || k == 0) begin : g_end
      assign rb_in[k] = 1'b1;
    end else if (k > UNITS) begin : g_int
      assign rb_in[k] = rb_out[k+1];
    end else begin : g_frac
      assign rb_in[k] = rb_out[k-1];
    end

    zbd_digit u_digit (
      .clk      (clk),
      .rst_n    (rst_ok),
      .load     (load),
      .din      (digits_in[4*k +: 4]),
      .blank_in (rb_in[k]),
      .lit      (lit),
      .blank_out(rb_out[k]),
      .seg_n    (seg_n[7*k +: 7])
    );
  end
endmodule

// File: rtl/zero_blank_display_chk.sv
module zero_blank_display_chk #(
  parameter int NUM_INT  = 4,
  parameter int NUM_FRAC = 4,
  parameter int PWM_W    = 8
) (
  input logic                            clk,
  input logic                            rst_ok,
  input logic                            load,
  input logic [4*(NUM_INT+NUM_FRAC)-1:0] digits_in,
  input logic [PWM_W-1:0]                duty,
  input logic [7*(NUM_INT+NUM_FRAC)-1:0] seg_n
);
  localparam int NDIG = NUM_INT + NUM_FRAC;
  localparam int UNITS = NUM_FRAC;
  localparam logic [PWM_W-1:0] FULL = '1;

  // R9
  dark_at_zero_duty_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (duty == '0) |=> (seg_n == '1));

  // R5
  top_zero_dark_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (load && digits_in[4*NDIG-1 -: 4] == 4'd0) |=> ##1 (seg_n[7*NDIG-1 -: 7] == 7'h7F));

  // R7
  last_frac_zero_dark_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (load && digits_in[3:0] == 4'd0) |=> ##1 (seg_n[6:0] == 7'h7F));

  // R6
  units_zero_shown_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (load && digits_in[4*UNITS +: 4] == 4'd0) ##1 (duty == FULL) |=> (seg_n[7*UNITS +: 7] == 7'h40));

  // R2
  hold_without_load_chk: assert property (@(posedge clk) disable iff (!rst_ok)
    (!load && duty == FULL) ##1 (!load && duty == FULL && $stable(duty)) |=> $stable(seg_n));
endmodule

bind zero_blank_display zero_blank_display_chk #(
  .NUM_INT(NUM_INT), .NUM_FRAC(NUM_FRAC), .PWM_W(PWM_W)
) u_chk (
  .clk(clk), .rst_ok(rst_ok), .load(load), .digits_in(digits_in),
  .duty(duty), .seg_n(seg_n)
);

// File: tb/tb_zero_blank_display.sv
`timescale 1ns/1ps
module tb_zero_blank_display;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        load;
  logic [31:0] digits_in;
  logic [7:0]  duty;
  logic [55:0] seg_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct { logic [55:0] exp; string tag; logic [31:0] val; } item_t;
  item_t sb[$];

  always #4 clk = ~clk;

  zero_blank_display dut (
    .clk(clk), .rst_n(rst_n), .load(load), .digits_in(digits_in),
    .duty(duty), .seg_n(seg_n)
  );

  function automatic logic [6:0] pat(input logic [3:0] v);
    case (v)
      4'd0: return ~7'b0111111;
      4'd1: return ~7'b0000110;
      4'd2: return ~7'b1011011;
      4'd3: return ~7'b1001111;
      4'd4: return ~7'b1100110;
      4'd5: return ~7'b1101101;
      4'd6: return ~7'b1111101;
      4'd7: return ~7'b0000111;
      4'd8: return ~7'b1111111;
      4'd9: return ~7'b1101111;
      default: return 7'h7F;
    endcase
  endfunction

  // Expected picture from the writing rules (R3..R8).
  function automatic logic [55:0] model(input logic [31:0] v);
    logic [55:0] r;
    bit lead, trail;
    lead = 1;
    for (int k = 7; k >= 4; k--) begin
      lead = lead && (v[4*k +: 4] == 4'd0) && (k != 4);
      r[7*k +: 7] = lead ? 7'h7F : pat(v[4*k +: 4]);
    end
    trail = 1;
    for (int k = 0; k <= 3; k++) begin
      trail = trail && (v[4*k +: 4] == 4'd0) && (k != 3);
      r[7*k +: 7] = trail ? 7'h7F : pat(v[4*k +: 4]);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [55:0] act, input logic [55:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [31:0] v, input string tag);
    item_t it;
    @(negedge clk);
    digits_in = v;
    load = 1'b1;
    it.exp = model(v); it.tag = tag; it.val = v;
    sb.push_back(it);
    @(negedge clk);
    load = 1'b0;
    digits_in = ~v;
    @(negedge clk);
  endtask

  // Monitor: compares one edge after capture (R1).
  initial begin
    item_t it;
    forever begin
      wait (sb.size() != 0);
      it = sb.pop_front();
      repeat (2) @(negedge clk);
      check(it.tag, seg_n, it.exp);
    end
  end

  task automatic count_lit(input logic [7:0] d, input int expct);
    int n;
    @(negedge clk);
    duty = d;
    repeat (4) @(negedge clk);
    n = 0;
    for (int i = 0; i < 255; i++) begin
      @(negedge clk);
      if (seg_n[34:28] != 7'h7F) n++;
    end
    check("R9 lit cycles per period", 56'(n), 56'(expct));
  endtask

  initial begin
    #(8ns * 200000);
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [55:0] held;
    rst_n = 1'b0; load = 1'b0; digits_in = '0; duty = 8'hFF;
    repeat (3) @(negedge clk);
    check("R10 reset dark", seg_n, {56{1'b1}});
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 dark during release", seg_n, {56{1'b1}});
    repeat (3) @(negedge clk);
    check("R10 reset digits zero", seg_n, model(32'h0));

    apply(32'h0060_0300, "R5 R7 60.03");
    apply(32'h0000_0000, "R6 R8 zero shows 0.0");
    apply(32'h1000_0001, "R5 R7 no suppression");
    apply(32'h1234_5678, "R3 glyphs 1-8");
    apply(32'h9090_0909, "R3 glyphs 9 0");
    apply(32'h0005_5000, "R5 R7 single digits");
    apply(32'h0A00_00B0, "R4 hex stops ripple");
    apply(32'h00C0_0D00, "R4 hex blank");
    apply(32'h0100_0010, "R5 R7 inner zeros");
    apply(32'h0003_0000, "R6 units and R8 tenths");

    // R2: load low, inputs wiggle, picture unchanged.
    @(negedge clk);
    held = seg_n;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      digits_in = $urandom;
    end
    @(negedge clk);
    check("R2 hold without load", seg_n, held);

    // R1 R5 R7: random digits weighted toward zero.
    for (int n = 0; n < 40; n++) begin
      logic [31:0] v;
      for (int k = 0; k < 8; k++)
        v[4*k +: 4] = ($urandom % 3 == 0) ? 4'($urandom % 16) : 4'd0;
      apply(v, "R1 random capture");
    end
    wait (sb.size() == 0);
    repeat (3) @(negedge clk);

    apply(32'h0000_0000, "R9 setup");
    repeat (2) @(negedge clk);
    count_lit(8'd0,   0);
    count_lit(8'd100, 100);
    count_lit(8'd1,   1);
    count_lit(8'hFF,  255);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule